// File: doc/BRIEF.md
# Predicated Vector Element Sequencer

This block runs the element loop behind one scalar-style operation that has been widened over a vector length. It takes three operand descriptors (two sources and one destination), each a 7-bit base register number plus a tag that marks the operand as scalar or vector. It also takes a predicate mask, a zeroing flag and a fail-first control. Element by element it hands the datapath a register index for each operand, together with either a write strobe or a zero-write strobe. The datapath accepts each element through a valid/ready handshake and returns a condition flag that fail-first mode tests.

The vector length is held inside the block. A set-length request supplies a requested length and a ceiling, and the block stores the smaller of the two, further capped at the element capacity. While a loop runs, the loop can stop early in three ways: after the first write to a scalar destination, at the first element that fails the fail-first test, or when a vector index would step past register 127. When fail-first stops the loop, the stored length is cut down to the number of the failing element.

Top module: `vec_elem_seq`

## Requirements
- R1: In element n, a vector-tagged operand presents index base+n and a scalar-tagged operand presents its base unchanged, on el_ra, el_rb and el_rt.
- R2: When the destination is scalar-tagged, the loop ends at the first accepted element, whether it is a write or a zero-write. done is high in the following cycle.
- R3: Bit n of pmask governs element n; with pmask_en low every bit counts as set. A clear bit with zero_en low skips the element and presents no el_valid. A clear bit with zero_en high presents the element with el_zero=1 and el_we=0. A set bit presents el_we=1 and el_zero=0.
- R4: Scalar sources with a vector destination give an insert when the mask has a single set bit, and a broadcast to every element when pmask_en is low.
- R5: Elements are presented in strictly ascending element number, and el_num equals the element number.
- R6: With ff_en high, an accepted element with el_we=1 passes when el_eq XOR ff_inv is 1. The first failing element ends the loop, and vl_o becomes that element's number. Zero-write elements are not tested.
- R7: A set-length request taken while idle sets vl_o to min(setvl_len, setvl_max, MAXEL) one cycle later.
- R8: A start with vl_o equal to 0 presents no element and pulses done in the next cycle.
- R9: An element that would present a vector index above 127 is not presented. idx_err rises and done pulses in the next cycle. idx_err clears on the next accepted start.
- R10: el_valid and the element fields hold steady until el_ready. done is a single-cycle pulse, and busy is low whenever el_valid could not be asserted.
- R11: start and setvl_req are ignored while busy is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| setvl_req | input | 1 | Set-length request |
| setvl_len | input | VLW | Requested vector length |
| setvl_max | input | VLW | Length ceiling for the request |
| vl_o | output | VLW | Current vector length |
| start | input | 1 | Begin a loop with the operand fields below |
| ra_base | input | 7 | First source base register |
| ra_vec | input | 1 | First source is vector-tagged |
| rb_base | input | 7 | Second source base register |
| rb_vec | input | 1 | Second source is vector-tagged |
| rt_base | input | 7 | Destination base register |
| rt_vec | input | 1 | Destination is vector-tagged |
| pmask | input | MAXEL | Predicate mask, bit n for element n |
| pmask_en | input | 1 | Use the predicate mask |
| zero_en | input | 1 | Zeroing mode for masked elements |
| ff_en | input | 1 | Fail-first enable |
| ff_inv | input | 1 | Invert the fail-first test |
| busy | output | 1 | Loop in progress |
| el_valid | output | 1 | Element presented |
| el_ready | input | 1 | Datapath accepts the element |
| el_num | output | VLW | Element number |
| el_ra | output | 7 | First source index |
| el_rb | output | 7 | Second source index |
| el_rt | output | 7 | Destination index |
| el_we | output | 1 | Write result strobe |
| el_zero | output | 1 | Write zero strobe |
| el_eq | input | 1 | Equal condition of the element result |
| done | output | 1 | One-cycle end-of-loop pulse |
| idx_err | output | 1 | Index stepped past 127 |

## Verification
The bench targets several corner cases. A scalar destination under a mask whose low bits are clear must write exactly once; a design that stopped on a skipped element would issue nothing. A design that kept stepping would produce a whole vector of writes to one register. Fail-first must cut the length to the failing element, not to the count of set mask bits, and must not test zero-writes; an off-by-one leaves a wrong vl_o. Bases near 127 must stop cleanly, without a wrapped index reaching register 0. A set-length or start arriving mid-loop must change neither the length nor the element fields.

// File: rtl/vseq_pkg.sv
package vseq_pkg;

    localparam int REG_W    = 7;
    localparam int REG_LAST = (1 << REG_W) - 1;

    typedef logic [REG_W-1:0] reg_idx_t;

    typedef struct packed {
        reg_idx_t base;
        logic     is_vec;
    } opnd_t;

    typedef struct packed {
        opnd_t ra;
        opnd_t rb;
        opnd_t rt;
        logic  pm_en;
        logic  zero;
        logic  ff;
        logic  inv;
    } inst_t;

    typedef enum logic {ST_IDLE, ST_RUN} st_e;

    function automatic int unsigned vl_clamp(input int unsigned req,
                                             input int unsigned lim,
                                             input int unsigned cap);
        int unsigned r;
        r = (req < lim) ? req : lim;
        return (r < cap) ? r : cap;
    endfunction

endpackage

// File: rtl/vseq_opidx.sv
module vseq_opidx
    import vseq_pkg::*;
#(
    parameter int VLW = 7
) (
    input  opnd_t          op,
    input  logic [VLW-1:0] elem,
    output reg_idx_t       idx,
    output logic           ovf
);
    localparam int SW = ((REG_W > VLW) ? REG_W : VLW) + 1;

    logic [SW-1:0] sum;

    always_comb begin
        sum = SW'(op.base) + (op.is_vec ? SW'(elem) : '0);
        idx = sum[REG_W-1:0];
        ovf = (sum > SW'(REG_LAST));
    end
endmodule

// File: rtl/vseq_vlreg.sv
module vseq_vlreg
    import vseq_pkg::*;
#(
    parameter int MAXEL = 64,
    parameter int VLW   = $clog2(MAXEL + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           set_en,
    input  logic [VLW-1:0] set_len,
    input  logic [VLW-1:0] set_max,
    input  logic           shrink_en,
    input  logic [VLW-1:0] shrink_val,
    output logic [VLW-1:0] vl
);
    always_ff @(posedge clk) begin
        if (rst)
            vl <= '0;
        else if (shrink_en)
            vl <= shrink_val;
        else if (set_en)
            vl <= VLW'(vl_clamp(int'(set_len), int'(set_max), MAXEL));
    end
endmodule

// File: rtl/vseq_ctrl.sv
module vseq_ctrl
    import vseq_pkg::*;
#(
    parameter int MAXEL = 64,
    parameter int VLW   = $clog2(MAXEL + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  inst_t            inst_in,
    input  logic [MAXEL-1:0] pmask_in,
    input  logic [VLW-1:0]   vl,
    input  logic             any_ovf,
    input  logic             el_ready,
    input  logic             el_eq,
    output inst_t            ins_q,
    output logic [VLW-1:0]   elem,
    output logic             busy,
    output logic             el_valid,
    output logic             el_we,
    output logic             el_zero,
    output logic             done,
    output logic             idx_err,
    output logic             shrink_en,
    output logic [VLW-1:0]   shrink_val
);
    st_e              st;
    logic [MAXEL-1:0] pmask_q;
    logic [MAXEL-1:0] pm_sh;
    logic             pbit, active, last, hs, ff_fail, finish, advance, running;

    always_comb begin
        running    = (st == ST_RUN);
        pm_sh      = pmask_q >> elem;
        pbit       = !ins_q.pm_en || pm_sh[0];
        active     = pbit || ins_q.zero;
        last       = ((elem + VLW'(1)) == vl);
        el_valid   = running && active && !any_ovf;
        el_we      = pbit;
        el_zero    = !pbit;
        hs         = el_valid && el_ready;
        ff_fail    = hs && ins_q.ff && pbit && (el_eq == ins_q.inv);
        finish     = running && ((active && any_ovf) ||
                                 (hs && (ff_fail || !ins_q.rt.is_vec || last)) ||
                                 (!active && last));
        advance    = running && !finish && (hs || !active);
        shrink_en  = ff_fail;
        shrink_val = elem;
        busy       = running;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            ins_q   <= '0;
            pmask_q <= '0;
            elem    <= '0;
            done    <= 1'b0;
            idx_err <= 1'b0;
        end else begin
            done <= 1'b0;
            if (st == ST_IDLE && start) begin
                ins_q   <= inst_in;
                pmask_q <= pmask_in;
                elem    <= '0;
                idx_err <= 1'b0;
                if (vl == '0) done <= 1'b1;
                else          st   <= ST_RUN;
            end
            if (finish) begin
                st   <= ST_IDLE;
                done <= 1'b1;
                if (active && any_ovf) idx_err <= 1'b1;
            end
            if (advance) elem <= elem + VLW'(1);
        end
    end
endmodule

// File: rtl/vec_elem_seq.sv
module vec_elem_seq
    import vseq_pkg::*;
#(
    parameter int MAXEL = 64,
    localparam int VLW  = $clog2(MAXEL + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             setvl_req,
    input  logic [VLW-1:0]   setvl_len,
    input  logic [VLW-1:0]   setvl_max,
    output logic [VLW-1:0]   vl_o,
    input  logic             start,
    input  logic [6:0]       ra_base,
    input  logic             ra_vec,
    input  logic [6:0]       rb_base,
    input  logic             rb_vec,
    input  logic [6:0]       rt_base,
    input  logic             rt_vec,
    input  logic [MAXEL-1:0] pmask,
    input  logic             pmask_en,
    input  logic             zero_en,
    input  logic             ff_en,
    input  logic             ff_inv,
    output logic             busy,
    output logic             el_valid,
    input  logic             el_ready,
    output logic [VLW-1:0]   el_num,
    output logic [6:0]       el_ra,
    output logic [6:0]       el_rb,
    output logic [6:0]       el_rt,
    output logic             el_we,
    output logic             el_zero,
    input  logic             el_eq,
    output logic             done,
    output logic             idx_err
);
    localparam int NOPS = 3;

    inst_t          inst_in, ins_q;
    logic [VLW-1:0] elem, shrink_val;
    logic           shrink_en;
    opnd_t          ops  [NOPS];
    reg_idx_t       idxs [NOPS];
    logic [NOPS-1:0] ovfs;

    always_comb begin
        inst_in.ra    = '{base: ra_base, is_vec: ra_vec};
        inst_in.rb    = '{base: rb_base, is_vec: rb_vec};
        inst_in.rt    = '{base: rt_base, is_vec: rt_vec};
        inst_in.pm_en = pmask_en;
        inst_in.zero  = zero_en;
        inst_in.ff    = ff_en;
        inst_in.inv   = ff_inv;
        ops[0] = ins_q.ra;
        ops[1] = ins_q.rb;
        ops[2] = ins_q.rt;
    end

    vseq_vlreg #(.MAXEL(MAXEL), .VLW(VLW)) u_vl (
        .clk(clk), .rst(rst),
        .set_en(setvl_req && !busy), .set_len(setvl_len), .set_max(setvl_max),
        .shrink_en(shrink_en), .shrink_val(shrink_val), .vl(vl_o)
    );

    for (genvar g = 0; g < NOPS; g++) begin : g_op
        vseq_opidx #(.VLW(VLW)) u_idx (
            .op(ops[g]), .elem(elem), .idx(idxs[g]), .ovf(ovfs[g])
        );
    end

    vseq_ctrl #(.MAXEL(MAXEL), .VLW(VLW)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .inst_in(inst_in), .pmask_in(pmask),
        .vl(vl_o), .any_ovf(|ovfs), .el_ready(el_ready), .el_eq(el_eq),
        .ins_q(ins_q), .elem(elem), .busy(busy), .el_valid(el_valid),
        .el_we(el_we), .el_zero(el_zero), .done(done), .idx_err(idx_err),
        .shrink_en(shrink_en), .shrink_val(shrink_val)
    );

    assign el_num = elem;
    assign el_ra  = idxs[0];
    assign el_rb  = idxs[1];
    assign el_rt  = idxs[2];
endmodule

// File: rtl/vseq_chk.sv
module vseq_chk
#(
    parameter int MAXEL = 64,
    localparam int VLW  = $clog2(MAXEL + 1)
) (
    input logic           clk,
    input logic           rst,
    input logic           setvl_req,
    input logic [VLW-1:0] setvl_len,
    input logic [VLW-1:0] setvl_max,
    input logic [VLW-1:0] vl_o,
    input logic           start,
    input logic           rt_vec,
    input logic           busy,
    input logic           el_valid,
    input logic           el_ready,
    input logic [VLW-1:0] el_num,
    input logic [6:0]     el_rt,
    input logic           el_we,
    input logic           el_zero,
    input logic           done,
    input logic           idx_err
);
    logic           dst_vec_q, seen_q;
    logic [VLW-1:0] last_num_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dst_vec_q  <= 1'b0;
            seen_q     <= 1'b0;
            last_num_q <= '0;
        end else begin
            if (start && !busy) begin
                dst_vec_q <= rt_vec;
                seen_q    <= 1'b0;
            end else if (el_valid && el_ready) begin
                seen_q     <= 1'b1;
                last_num_q <= el_num;
            end
        end
    end

    assert_scalar_dst_end_R2: assert property (@(posedge clk) disable iff (rst)
        el_valid && el_ready && !dst_vec_q |=> done);

    assert_one_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        el_valid |-> (el_we ^ el_zero));

    assert_ascending_R5: assert property (@(posedge clk) disable iff (rst)
        el_valid && el_ready && seen_q |-> el_num > last_num_q);

    assert_vl_clamp_R7: assert property (@(posedge clk) disable iff (rst)
        setvl_req && !busy |=>
            vl_o == VLW'(vseq_pkg::vl_clamp(int'($past(setvl_len)), int'($past(setvl_max)), MAXEL)));

    assert_err_ends_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(idx_err) |-> done);

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        el_valid && !el_ready |=> el_valid && $stable(el_num) && $stable(el_rt));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !el_valid);

    assert_busy_len_R11: assert property (@(posedge clk) disable iff (rst)
        busy && $past(busy) && !done |-> $stable(vl_o));
endmodule

bind vec_elem_seq vseq_chk #(.MAXEL(MAXEL)) u_chk (.*);

// File: tb/tb_vec_elem_seq.sv
module tb_vec_elem_seq;
    localparam int MAXEL = 64;
    localparam int VLW   = $clog2(MAXEL + 1);
    localparam int EW    = VLW + 23;

    logic clk = 0, rst = 1;
    logic setvl_req = 0, start = 0, el_ready = 0, el_eq;
    logic [VLW-1:0] setvl_len = 0, setvl_max = 0, vl_o, el_num;
    logic [6:0] ra_base = 0, rb_base = 0, rt_base = 0, el_ra, el_rb, el_rt;
    logic ra_vec = 0, rb_vec = 0, rt_vec = 0, pmask_en = 0, zero_en = 0, ff_en = 0, ff_inv = 0;
    logic [MAXEL-1:0] pmask = 0, eq_pat = '1;
    logic busy, el_valid, el_we, el_zero, done, idx_err;

    int checks = 0, failures = 0, cur_vl = 0;
    int exp_n, exp_vl;
    bit exp_err;
    logic [EW-1:0] exp_el [MAXEL];

    always #4 clk = ~clk;
    always_comb el_eq = eq_pat[el_num[5:0]];

    vec_elem_seq #(.MAXEL(MAXEL)) dut (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic int clampf(int l, int m);
        int r = (l < m) ? l : m;
        return (r < MAXEL) ? r : MAXEL;
    endfunction

    task automatic model();
        exp_n = 0; exp_vl = cur_vl; exp_err = 0;
        for (int e = 0; e < cur_vl; e++) begin
            bit p = !pmask_en || pmask[e];
            int a = ra_base + (ra_vec ? e : 0);
            int b = rb_base + (rb_vec ? e : 0);
            int t = rt_base + (rt_vec ? e : 0);
            if (!p && !zero_en) continue;
            if (a > 127 || b > 127 || t > 127) begin exp_err = 1; break; end
            exp_el[exp_n] = {VLW'(e), 7'(a), 7'(b), 7'(t), p, !p};
            exp_n++;
            if (ff_en && p && ((eq_pat[e] ^ ff_inv) == 1'b0)) begin exp_vl = e; break; end
            if (!rt_vec) break;
        end
    endtask

    task automatic setvl(input int len, input int mx);
        setvl_len = VLW'(len); setvl_max = VLW'(mx); setvl_req = 1;
        @(negedge clk); setvl_req = 0;
        cur_vl = clampf(len, mx);
        chk(vl_o == VLW'(cur_vl), "R7", "setvl length", vl_o, cur_vl);
    endtask

    task automatic drive_op(input int ra, input bit rav, input int rb, input bit rbv,
                            input int rt, input bit rtv, input logic [63:0] pm,
                            input bit pme, input bit z, input bit ff, input bit inv,
                            input logic [63:0] eqp);
        ra_base = 7'(ra); ra_vec = rav; rb_base = 7'(rb); rb_vec = rbv;
        rt_base = 7'(rt); rt_vec = rtv; pmask = pm; pmask_en = pme;
        zero_en = z; ff_en = ff; ff_inv = inv; eq_pat = eqp;
        model();
        start = 1;
        @(negedge clk); start = 0;
    endtask

    task automatic finish_op(input string req, input int pct);
        int k = 0, cyc = 0;
        bit got = 0;
        while (!got && cyc < 3000) begin
            if (done) got = 1;
            else begin
                el_ready = ($urandom % 100) < pct;
                #1;
                if (el_valid && el_ready) begin
                    logic [EW-1:0] act = {el_num, el_ra, el_rb, el_rt, el_we, el_zero};
                    chk(k < exp_n && act == exp_el[k], req, "element", act,
                        (k < exp_n) ? exp_el[k] : '0);
                    k++;
                end
                @(negedge clk);
                cyc++;
            end
        end
        el_ready = 0;
        chk(got, req, "run timeout", cyc, 0);
        chk(k == exp_n, req, "element count", k, exp_n);
        chk(vl_o == VLW'(exp_vl), req, "final length", vl_o, exp_vl);
        chk(idx_err == exp_err, req, "index error", idx_err, exp_err);
        cur_vl = exp_vl;
        @(negedge clk);
        chk(!done, "R10", "done single pulse", done, 0);
    endtask

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20210101));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(vl_o == 0 && !busy && !el_valid && !done && !idx_err, "R10", "reset state",
            {vl_o, busy, el_valid, done, idx_err}, 0);

        setvl(10, 16);
        setvl(20, 16);
        setvl(100, 80);

        setvl(8, 64);   // R1 mixed tags
        drive_op(4, 1, 9, 0, 20, 1, '0, 0, 0, 0, 0, '1);
        finish_op("R1", 60);

        drive_op(3, 0, 5, 0, 40, 1, '0, 0, 0, 0, 0, '1);   // R4 broadcast
        finish_op("R4", 100);
        drive_op(3, 0, 5, 0, 40, 1, 64'h20, 1, 0, 0, 0, '1); // R4 insert
        finish_op("R4", 70);

        drive_op(10, 1, 30, 1, 50, 1, 64'hA5, 1, 0, 0, 0, '1); // R3 skip
        finish_op("R3", 80);
        drive_op(10, 1, 30, 1, 50, 1, 64'hA5, 1, 1, 0, 0, '1); // R3 zeroing
        finish_op("R3", 80);

        drive_op(1, 1, 2, 1, 7, 0, 64'hF8, 1, 0, 0, 0, '1);  // R2 scalar dst
        finish_op("R2", 50);
        drive_op(1, 1, 2, 1, 7, 0, 64'hF8, 1, 1, 0, 0, '1);  // R2 zero-write ends
        finish_op("R2", 50);

        setvl(12, 12);  // R6 fail at element 5
        drive_op(0, 1, 0, 1, 60, 1, '0, 0, 0, 1, 0, ~64'h20);
        finish_op("R6", 70);
        chk(vl_o == 5, "R6", "shrunk length", vl_o, 5);
        setvl(12, 12);  // R6 inverted test, zero-write at 2 not tested
        drive_op(0, 1, 0, 1, 60, 1, ~64'h4, 1, 1, 1, 1, 64'h0C);
        finish_op("R6", 70);

        setvl(0, 10);   // R8
        drive_op(0, 1, 0, 1, 0, 1, '0, 0, 0, 0, 0, '1);
        finish_op("R8", 100);

        setvl(8, 8);    // R9
        drive_op(125, 1, 0, 0, 0, 1, '0, 0, 0, 0, 0, '1);
        finish_op("R9", 100);
        drive_op(1, 1, 0, 0, 0, 1, '0, 0, 0, 0, 0, '1);
        finish_op("R9", 100);

        setvl(6, 6);    // R11 interference while busy
        drive_op(1, 1, 2, 1, 3, 1, '0, 0, 0, 0, 0, '1);
        setvl_len = 2; setvl_max = 2; setvl_req = 1;
        ra_base = 50; start = 1;
        @(negedge clk);
        setvl_req = 0; start = 0; ra_base = 1;
        chk(vl_o == 6, "R11", "length during busy", vl_o, 6);
        chk(el_valid && el_ra == 1, "R11", "fields during busy", el_ra, 1);
        finish_op("R11", 60);

        for (int i = 0; i < 60; i++) begin   // R5 random mix
            setvl($urandom % 70, 10 + $urandom % 60);
            drive_op($urandom % 128, $urandom % 2, $urandom % 128, $urandom % 2,
                     $urandom % 128, ($urandom % 4) != 0,
                     {$urandom, $urandom}, $urandom % 2, $urandom % 2,
                     ($urandom % 3) == 0, $urandom % 2,
                     {$urandom, $urandom} | {$urandom, $urandom} | {$urandom, $urandom});
            finish_op("R5", 30 + $urandom % 70);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule